// File: doc/BRIEF.md
# Stack and Indirect-Jump Group Unit

This unit executes the three group instructions whose ModR/M middle field selects the operation. The operations are an indirect jump, a push of a memory operand, and a pop into a memory operand. The unit receives the resolved effective address and the current stack pointer when it is started. It sequences one or two accesses on a 32-bit word memory port, waiting on a ready handshake for each. It finishes with a one-cycle done pulse, and in that same cycle it presents the new instruction pointer or the new stack pointer as a write-enable and data pair.

Push and pop each move a word between two different places. Push reads the operand and then writes it onto the stack. Pop reads the stack top and then writes it to the operand location. Both therefore run a read phase followed by a write phase. Jump only reads. A selector outside the three supported encodings produces an error pulse. In that case nothing is accessed and nothing is written. Address generation is done elsewhere, and all addresses on the port are byte addresses of whole words.

Top module: `stkj_unit`

## Requirements
- R1: The operation is chosen from `opcode` and the sub-operation field `modrm[5:3]`. Opcode 0xFF with field 4 is jump. Opcode 0xFF with field 6 is push. Opcode 0x8F with field 0 is pop. The other `modrm` bits have no effect, and at most one of `ip_wr_en` and `sp_wr_en` is ever high.
- R2: Jump makes exactly one read, at `ea`. In the done cycle it raises `ip_wr_en` with `ip_wr_data` equal to the word read. It makes no write and does not raise `sp_wr_en`.
- R3: Push first reads at `ea`. It then writes that word at `sp_in - 4`. In the done cycle it raises `sp_wr_en` with `sp_wr_data = sp_in - 4`.
- R4: Pop first reads at `sp_in`. It then writes that word at `ea`. In the done cycle it raises `sp_wr_en` with `sp_wr_data = sp_in + 4`.
- R5: An access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until a cycle with `mem_ready` high. The next phase starts only after that cycle.
- R6: For any other opcode or field value, `done` and `err` are high together in the cycle after the start was taken. There is no memory request and no write of the instruction pointer or the stack pointer.
- R7: `done` is a single-cycle pulse, and there is exactly one per accepted start. A `start` raised while an operation is in progress is ignored.
- R8: After reset, `mem_req`, `done`, `err`, `ip_wr_en` and `sp_wr_en` are all low.
- R9: Stack pointer arithmetic wraps modulo 2^32. A push with `sp_in = 0` gives 0xFFFFFFFC, and a pop with `sp_in = 0xFFFFFFFC` gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; taken only when idle |
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModR/M byte; bits 5:3 select the sub-operation |
| ea | input | 32 | Resolved r/m effective address |
| sp_in | input | 32 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Unsupported sub-operation (with done) |
| ip_wr_en | output | 1 | Load the instruction pointer |
| ip_wr_data | output | 32 | New instruction pointer |
| sp_wr_en | output | 1 | Load the stack pointer |
| sp_wr_data | output | 32 | New stack pointer |

## Verification
The assertions assume two things about the memory port. First, `mem_rdata` is valid in the cycle that `mem_ready` is high. Second, `mem_ready` is only raised while a request is pending. The bench memory model keeps to both: it raises ready only against a live request, after a chosen wait of zero to three cycles. It returns read data as a fixed arithmetic function of the address. The sweep covers every opcode class, all eight field values and several wait counts. It adds stack pointer wrap cases and a run in which `start` is raised with an invalid operation while an operation is in progress.

// File: rtl/stkj_pkg.sv
package stkj_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned WORD_BYTES = XLEN / 8;

  localparam logic [7:0] OPC_GRP_FF = 8'hFF;
  localparam logic [7:0] OPC_GRP_8F = 8'h8F;
  localparam logic [2:0] SUB_JUMP   = 3'd4;
  localparam logic [2:0] SUB_PUSH   = 3'd6;
  localparam logic [2:0] SUB_POP    = 3'd0;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {OP_JUMP, OP_PUSH, OP_POP, OP_BAD} grp_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FINISH} seq_st_e;

  function automatic word_t stack_down(word_t sp);
    return sp - word_t'(WORD_BYTES);
  endfunction

  function automatic word_t stack_up(word_t sp);
    return sp + word_t'(WORD_BYTES);
  endfunction

  function automatic logic [2:0] subop_of(logic [7:0] modrm);
    return modrm[5:3];
  endfunction
endpackage

// File: rtl/stkj_decode.sv
module stkj_decode
  import stkj_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  output grp_op_e    op
);
  logic [2:0] sub;
  assign sub = subop_of(modrm);

  always_comb begin
    op = OP_BAD;
    if (opcode == OPC_GRP_FF) begin
      if (sub == SUB_JUMP)      op = OP_JUMP;
      else if (sub == SUB_PUSH) op = OP_PUSH;
    end else if (opcode == OPC_GRP_8F) begin
      if (sub == SUB_POP)       op = OP_POP;
    end
  end
endmodule

// File: rtl/stkj_seq.sv
module stkj_seq
  import stkj_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  grp_op_e op_in,
  input  logic    mem_ready,
  output seq_st_e st,
  output grp_op_e op_q,
  output logic    accept,
  output logic    read_fire
);
  seq_st_e st_n;

  assign accept    = start && (st == ST_IDLE);
  assign read_fire = (st == ST_READ) && mem_ready;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:   if (start) st_n = (op_in == OP_BAD) ? ST_FINISH : ST_READ;
      ST_READ:   if (mem_ready) st_n = (op_q == OP_JUMP) ? ST_FINISH : ST_WRITE;
      ST_WRITE:  if (mem_ready) st_n = ST_FINISH;
      ST_FINISH: st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      op_q <= OP_BAD;
    end else begin
      st <= st_n;
      if (accept) op_q <= op_in;
    end
  end
endmodule

// File: rtl/stkj_hold.sv
module stkj_hold
  import stkj_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  read_fire,
  input  word_t ea_in,
  input  word_t sp_in,
  input  word_t rdata,
  output word_t ea_q,
  output word_t sp_q,
  output word_t val_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      sp_q  <= '0;
      val_q <= '0;
    end else begin
      if (accept) begin
        ea_q <= ea_in;
        sp_q <= sp_in;
      end
      if (read_fire) val_q <= rdata;
    end
  end
endmodule

// File: rtl/stkj_unit.sv
module stkj_unit
  import stkj_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  modrm,
  input  logic [31:0] ea,
  input  logic [31:0] sp_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  output logic        done,
  output logic        err,
  output logic        ip_wr_en,
  output logic [31:0] ip_wr_data,
  output logic        sp_wr_en,
  output logic [31:0] sp_wr_data
);
  grp_op_e op_dec, op_q;
  seq_st_e st;
  logic    accept, read_fire;
  word_t   ea_q, sp_q, val_q;
  word_t   sp_after;

  stkj_decode u_dec (.opcode(opcode), .modrm(modrm), .op(op_dec));

  stkj_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_dec),
    .mem_ready(mem_ready), .st(st), .op_q(op_q),
    .accept(accept), .read_fire(read_fire)
  );

  stkj_hold u_hold (
    .clk(clk), .rst_n(rst_n), .accept(accept), .read_fire(read_fire),
    .ea_in(ea), .sp_in(sp_in), .rdata(mem_rdata),
    .ea_q(ea_q), .sp_q(sp_q), .val_q(val_q)
  );

  assign sp_after = (op_q == OP_PUSH) ? stack_down(sp_q) : stack_up(sp_q);

  always_comb begin
    mem_req   = (st == ST_READ) || (st == ST_WRITE);
    mem_we    = (st == ST_WRITE);
    mem_addr  = '0;
    mem_wdata = '0;
    if (st == ST_READ) begin
      mem_addr = (op_q == OP_POP) ? sp_q : ea_q;
    end else if (st == ST_WRITE) begin
      mem_addr  = (op_q == OP_PUSH) ? stack_down(sp_q) : ea_q;
      mem_wdata = val_q;
    end
  end

  assign done       = (st == ST_FINISH);
  assign err        = done && (op_q == OP_BAD);
  assign ip_wr_en   = done && (op_q == OP_JUMP);
  assign ip_wr_data = val_q;
  assign sp_wr_en   = done && ((op_q == OP_PUSH) || (op_q == OP_POP));
  assign sp_wr_data = sp_after;
endmodule

// File: rtl/stkj_unit_chk.sv
module stkj_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata,
  input logic        mem_ready,
  input logic        done,
  input logic        err,
  input logic        ip_wr_en,
  input logic [31:0] ip_wr_data,
  input logic        sp_wr_en
);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !mem_req && !ip_wr_en && !sp_wr_en));

  p_read_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> !mem_we);

  p_write_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> ($past(mem_ready) && mem_wdata == $past(mem_rdata)));

  p_jump_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ip_wr_en |-> ($past(mem_ready) && ip_wr_data == $past(mem_rdata)));

  p_single_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ip_wr_en && sp_wr_en));
endmodule

bind stkj_unit stkj_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
  .mem_ready(mem_ready), .done(done), .err(err), .ip_wr_en(ip_wr_en),
  .ip_wr_data(ip_wr_data), .sp_wr_en(sp_wr_en)
);

// File: tb/tb_stkj_unit.sv
module tb_stkj_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [7:0]  opcode = 0, modrm = 0;
  logic [31:0] ea = 0, sp_in = 0;
  logic        mem_req, mem_we, done, err, ip_wr_en, sp_wr_en;
  logic [31:0] mem_addr, mem_wdata, ip_wr_data, sp_wr_data;
  logic [31:0] mem_rdata = 0;
  logic        mem_ready = 0;

  int n_chk = 0, n_fail = 0;
  int lat = 0, wcnt = 0, stab_bad = 0, n_acc = 0, n_done = 0, cyc_total = 0;
  logic        acc_we [4];
  logic [31:0] acc_addr [4];
  logic [31:0] acc_wd [4];
  logic [31:0] f_addr, f_wd;
  logic        f_we;

  stkj_unit dut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] mdl(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5AC30F96;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and monitors
  always @(negedge clk) begin
    cyc_total++;
    if (done) n_done++;
    if (rst_n) begin
      if (mem_ready) begin mem_ready = 0; wcnt = 0; end
      if (mem_req) begin
        if (wcnt == 0) begin f_addr = mem_addr; f_we = mem_we; f_wd = mem_wdata; end
        else if (mem_addr !== f_addr || mem_we !== f_we || mem_wdata !== f_wd) stab_bad++;
        if (wcnt >= lat) begin
          mem_ready = 1;
          mem_rdata = mdl(mem_addr);
          if (n_acc < 4) begin
            acc_we[n_acc] = mem_we; acc_addr[n_acc] = mem_addr; acc_wd[n_acc] = mem_wdata;
          end
          n_acc++;
        end else wcnt++;
      end else wcnt = 0;
    end
  end

  always @(negedge clk) begin
    if (cyc_total > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_op(logic [7:0] opc, logic [7:0] mr, logic [31:0] a,
                        logic [31:0] sp, int l, bit intf);
    int cyc = 0;
    int d0;
    bit got = 0;
    logic e, ipe, spe;
    logic [31:0] ipd, spd;
    logic [2:0] sub = mr[5:3];
    @(negedge clk);
    lat = l; n_acc = 0; stab_bad = 0;
    d0 = n_done;
    opcode = opc; modrm = mr; ea = a; sp_in = sp; start = 1;
    while (!got && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (intf && cyc <= 2) begin start = 1; opcode = 8'h01; end
      else start = 0;
      if (done) begin
        got = 1; e = err; ipe = ip_wr_en; ipd = ip_wr_data; spe = sp_wr_en; spd = sp_wr_data;
      end
    end
    start = 0;
    @(negedge clk);
    check(got, "R7 done seen", 32'(got), 1);
    check(!done && (n_done - d0 == 1), "R7 single done", 32'(n_done - d0), 1);
    check(stab_bad == 0, "R5 request stable", 32'(stab_bad), 0);
    if (opc == 8'hFF && sub == 3'd4) begin
      check(n_acc == 1 && !acc_we[0] && acc_addr[0] == a, "R2 jump read", acc_addr[0], a);
      check(ipe && !spe && !e && ipd == mdl(a), "R2 jump target", ipd, mdl(a));
    end else if (opc == 8'hFF && sub == 3'd6) begin
      check(n_acc == 2 && !acc_we[0] && acc_addr[0] == a, "R3 push read", acc_addr[0], a);
      check(acc_we[1] && acc_addr[1] == sp - 32'd4 && acc_wd[1] == mdl(a),
            "R3 push write", acc_wd[1], mdl(a));
      check(spe && !ipe && !e && spd == sp - 32'd4, "R3 push sp", spd, sp - 32'd4);
    end else if (opc == 8'h8F && sub == 3'd0) begin
      check(n_acc == 2 && !acc_we[0] && acc_addr[0] == sp, "R4 pop read", acc_addr[0], sp);
      check(acc_we[1] && acc_addr[1] == a && acc_wd[1] == mdl(sp),
            "R4 pop write", acc_wd[1], mdl(sp));
      check(spe && !ipe && !e && spd == sp + 32'd4, "R4 pop sp", spd, sp + 32'd4);
    end else begin
      check(e && !ipe && !spe && n_acc == 0, "R6 invalid quiet", 32'(n_acc), 0);
      check(cyc == 1, "R6 error latency", 32'(cyc), 1);
    end
  endtask

  initial begin
    logic [7:0] opcs [3];
    opcs[0] = 8'hFF; opcs[1] = 8'h8F; opcs[2] = 8'h01;
    repeat (3) @(negedge clk);
    check(!mem_req && !done && !err && !ip_wr_en && !sp_wr_en, "R8 reset state",
          {27'd0, mem_req, done, err, ip_wr_en, sp_wr_en}, 0);
    rst_n = 1;
    // R1 sweep: every opcode class, every field value, several latencies
    for (int o = 0; o < 3; o++)
      for (int s = 0; s < 8; s++)
        for (int l = 0; l < 3; l++)
          run_op(opcs[o], {2'b00, 3'(s), 3'b011}, 32'h100 + 32'(s * 8 + l * 64),
                 32'h2000 - 32'(s * 4 + o * 256), l, 0);
    // R1: other modrm bits ignored
    run_op(8'hFF, 8'hE6, 32'h0000_0440, 32'h800, 1, 0);
    run_op(8'hFF, 8'h37, 32'h0000_0444, 32'h800, 0, 0);
    run_op(8'h8F, 8'hC7, 32'h0000_0448, 32'h800, 2, 0);
    // R3 push operand at the stack pointer itself
    run_op(8'hFF, 8'h30, 32'h0000_0014, 32'h14, 3, 0);
    // R9 wrap
    run_op(8'hFF, 8'h30, 32'h0000_0060, 32'h0, 1, 0);
    run_op(8'h8F, 8'h00, 32'h0000_0060, 32'hFFFF_FFFC, 1, 0);
    check(1'b1, "R9 wrap cases run", 0, 0);
    // R7 start ignored while busy
    run_op(8'hFF, 8'h30, 32'h0000_0200, 32'h400, 3, 1);
    run_op(8'h8F, 8'h00, 32'h0000_0204, 32'h400, 3, 1);
    repeat (3) @(negedge clk);
    check(!mem_req && !done, "R7 idle after ignored start", 32'(mem_req), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule